// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 64-bit virtual address into a 48-bit physical address. It walks up to four levels of in-memory translation tables with a 4 KiB granule. A request carries the address and a flag that marks a store. The walker picks one of two table base inputs from the sign-extension bits of the address. It then fetches one 64-bit descriptor per level through a read port that allows one outstanding read. The walk ends in one of two ways. A page or block descriptor yields a physical address. An invalid descriptor yields a data-abort syndrome that records the failing level, and the faulting address is captured as well.

Table descriptors that the walker reads are kept in a small walk cache. The key is the base selector, the level and the address prefix. A later walk that hits the cache skips the fetch for that level and continues from the cached next-level base. The cache does not watch table memory, so an entry can become stale. Only the invalidate input removes entries. After changing a table, software must pulse that input.

Top module: `ptw_walker`

## Requirements
- R1: When req_va[63:48] is all ones, the walk starts from base_hi. When it is all zeros, the walk starts from base_lo. The level-0 descriptor is read at that base with bits [11:0] cleared, plus 8 × req_va[47:39].
- R2: When req_va[63:48] is neither all ones nor all zeros, the walk issues no descriptor read. It returns a fault with status 0b000100.
- R3: The level index fields are va[47:39], va[38:30], va[29:21] and va[20:12] for levels 0, 1, 2 and 3. Each descriptor address is {table base[47:12], index, 3'b000}.
- R4: At levels 0 to 2, a descriptor with bits[1:0] = 0b11 is a table descriptor. Its bits [47:12] give the base of the next-level table.
- R5: At level 3, a descriptor with bits[1:0] = 0b11 is a page. resp_pa is {desc[47:12], va[11:0]}.
- R6: At level 1 or level 2, bits[1:0] = 0b01 marks a block. resp_pa is {desc[47:30], va[29:0]} at level 1 and {desc[47:21], va[20:0]} at level 2.
- R7: Bits[1:0] of 0b00 or 0b10 are invalid at every level, and 0b01 is invalid at level 0 and level 3. An invalid descriptor at level L ends the walk with resp_fault = 1. The syndrome then has [31:26] = 0b100101, [6] = the store flag, [5:0] = {4'b0001, L}, and every other bit zero.
- R8: fault_va takes the full request address on each fault and holds it through later successful walks.
- R9: A repeated walk that hits the cache for levels 0 to 2 reads only the level-3 descriptor. Cached pointers keep being used after table memory changes.
- R10: A one-cycle pulse on inval removes every cache entry. After that, the next walk starts again with a level-0 fetch.
- R11: req_ready is high only when the walker is idle. mem_req_valid and mem_req_addr hold steady until mem_req_ready is high.
- R12: resp_valid is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken |
| req_va | input | 64 | Virtual address to translate |
| req_write | input | 1 | Access is a store |
| base_lo | input | 48 | Table base for the low address region |
| base_hi | input | 48 | Table base for the high address region |
| inval | input | 1 | Clear the walk cache |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 48 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor data returned |
| mem_rsp_data | input | 64 | Descriptor value |
| resp_valid | output | 1 | Walk result pulse |
| resp_fault | output | 1 | Walk ended in a fault |
| resp_pa | output | 48 | Physical address (zero on fault) |
| resp_syndrome | output | 32 | Abort syndrome (zero on success) |
| fault_va | output | 64 | Address of the most recent fault |

## Verification
The assertions rely on two assumptions about the memory side. First, mem_rsp_valid arrives only once per accepted read and only after the handshake. Second, req_valid may stay high while the walker is busy, without effect. The bench memory model returns data exactly one cycle after each accepted read and never otherwise. It can hold mem_req_ready low for several cycles to stretch the request phase. Table contents are changed only between walks, and inval is pulsed only while the walker is idle, so every check has a single expected result.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W     = 48;
    localparam int IDX_W    = 9;
    localparam int GRAN_W   = 12;
    localparam int LVL_W    = 2;
    localparam int OA_W     = VA_W - GRAN_W;
    localparam int PFX_W    = 3 * IDX_W;
    localparam int KEY_W    = 1 + LVL_W + PFX_W;
    localparam int DESC_W   = 64;
    localparam int SYN_W    = 32;
    localparam logic [5:0] EC_ABORT_SAME = 6'b100101;

    typedef enum logic [1:0] {K_INVALID, K_TABLE, K_BLOCK, K_PAGE} desc_kind_e;
    typedef enum logic [2:0] {S_IDLE, S_LOOKUP, S_REQ, S_WAIT, S_DONE} walk_state_e;

    function automatic logic [IDX_W-1:0] level_index(input logic [VA_W-1:0] va,
                                                     input logic [LVL_W-1:0] lvl);
        logic [VA_W-1:0] sh;
        sh = va >> (39 - 9 * int'(lvl));
        return sh[IDX_W-1:0];
    endfunction

    function automatic logic [KEY_W-1:0] cache_key(input logic sel,
                                                   input logic [LVL_W-1:0] lvl,
                                                   input logic [VA_W-1:0] va);
        logic [PFX_W-1:0] pfx;
        logic [PFX_W-1:0] msk;
        pfx = va[VA_W-1:VA_W-PFX_W];
        msk = {PFX_W{1'b1}} << (9 * (2 - int'(lvl)));
        return {sel, lvl, pfx & msk};
    endfunction

    function automatic logic [SYN_W-1:0] abort_syndrome(input logic wr,
                                                        input logic [LVL_W-1:0] lvl);
        return {EC_ABORT_SAME, 19'd0, wr, 4'b0001, lvl};
    endfunction
endpackage

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
    import ptw_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [VA_W-1:0]   va,
    output desc_kind_e        kind,
    output logic [OA_W-1:0]   next_base,
    output logic [VA_W-1:0]   pa
);
    always_comb begin
        unique case (desc[1:0])
            2'b11:   kind = (lvl == 2'd3) ? K_PAGE : K_TABLE;
            2'b01:   kind = (lvl == 2'd1 || lvl == 2'd2) ? K_BLOCK : K_INVALID;
            default: kind = K_INVALID;
        endcase
    end

    assign next_base = desc[VA_W-1:GRAN_W];

    always_comb begin
        unique case (lvl)
            2'd1:    pa = {desc[47:30], va[29:0]};
            2'd2:    pa = {desc[47:21], va[20:0]};
            default: pa = {desc[47:12], va[11:0]};
        endcase
    end
endmodule

// File: rtl/ptw_walk_cache.sv
module ptw_walk_cache #(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 30,
    parameter int PTR_W   = 36
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inval,
    input  logic [KEY_W-1:0] lk_key,
    output logic             hit,
    output logic [PTR_W-1:0] hit_ptr,
    input  logic             fill_en,
    input  logic [KEY_W-1:0] fill_key,
    input  logic [PTR_W-1:0] fill_ptr
);
    localparam int VIC_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] vld;
    logic [KEY_W-1:0]   keys [ENTRIES];
    logic [PTR_W-1:0]   ptrs [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [VIC_W-1:0]   victim;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign match[g] = vld[g] && (keys[g] == lk_key);
    end

    always_comb begin
        hit     = |match;
        hit_ptr = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) hit_ptr = ptrs[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || inval) begin
            vld    <= '0;
            victim <= '0;
        end else if (fill_en) begin
            vld[victim]  <= 1'b1;
            keys[victim] <= fill_key;
            ptrs[victim] <= fill_ptr;
            victim <= (int'(victim) == ENTRIES - 1) ? '0 : victim + 1'b1;
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int CACHE_ENTRIES = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [63:0]         req_va,
    input  logic                req_write,
    input  logic [VA_W-1:0]     base_lo,
    input  logic [VA_W-1:0]     base_hi,
    input  logic                inval,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [VA_W-1:0]     mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [DESC_W-1:0]   mem_rsp_data,
    output logic                resp_valid,
    output logic                resp_fault,
    output logic [VA_W-1:0]     resp_pa,
    output logic [SYN_W-1:0]    resp_syndrome,
    output logic [63:0]         fault_va
);
    walk_state_e      state;
    logic [LVL_W-1:0] lvl;
    logic [63:0]      va_q;
    logic             wr_q;
    logic             sel_q;
    logic [OA_W-1:0]  base_q;

    logic             top_ones, top_zero;
    logic [KEY_W-1:0] cur_key;
    logic             c_hit;
    logic [OA_W-1:0]  c_ptr;
    logic             lk_hit;
    desc_kind_e       kind;
    logic [OA_W-1:0]  nxt_base;
    logic [VA_W-1:0]  leaf_pa;
    logic             fill_en;

    assign top_ones = &req_va[63:48];
    assign top_zero = ~|req_va[63:48];
    assign cur_key  = cache_key(sel_q, lvl, va_q[VA_W-1:0]);
    assign lk_hit   = (state == S_LOOKUP) && c_hit && (lvl != 2'd3);
    assign fill_en  = (state == S_WAIT) && mem_rsp_valid && (kind == K_TABLE);

    ptw_walk_cache #(
        .ENTRIES (CACHE_ENTRIES),
        .KEY_W   (KEY_W),
        .PTR_W   (OA_W)
    ) u_cache (
        .clk      (clk),
        .rst      (rst),
        .inval    (inval),
        .lk_key   (cur_key),
        .hit      (c_hit),
        .hit_ptr  (c_ptr),
        .fill_en  (fill_en),
        .fill_key (cur_key),
        .fill_ptr (nxt_base)
    );

    ptw_desc_decode u_dec (
        .desc      (mem_rsp_data),
        .lvl       (lvl),
        .va        (va_q[VA_W-1:0]),
        .kind      (kind),
        .next_base (nxt_base),
        .pa        (leaf_pa)
    );

    assign req_ready     = (state == S_IDLE);
    assign mem_req_valid = (state == S_REQ);
    assign mem_req_addr  = {base_q, level_index(va_q[VA_W-1:0], lvl), 3'b000};
    assign resp_valid    = (state == S_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= S_IDLE;
            lvl           <= '0;
            va_q          <= '0;
            wr_q          <= 1'b0;
            sel_q         <= 1'b0;
            base_q        <= '0;
            resp_fault    <= 1'b0;
            resp_pa       <= '0;
            resp_syndrome <= '0;
            fault_va      <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    va_q   <= req_va;
                    wr_q   <= req_write;
                    sel_q  <= top_ones;
                    lvl    <= '0;
                    base_q <= top_ones ? base_hi[VA_W-1:GRAN_W] : base_lo[VA_W-1:GRAN_W];
                    if (!top_ones && !top_zero) begin
                        resp_fault    <= 1'b1;
                        resp_pa       <= '0;
                        resp_syndrome <= abort_syndrome(req_write, 2'd0);
                        fault_va      <= req_va;
                        state         <= S_DONE;
                    end else begin
                        state <= S_LOOKUP;
                    end
                end
                S_LOOKUP: begin
                    if (lk_hit) begin
                        base_q <= c_ptr;
                        lvl    <= lvl + 2'd1;
                    end else begin
                        state <= S_REQ;
                    end
                end
                S_REQ: if (mem_req_ready) state <= S_WAIT;
                S_WAIT: if (mem_rsp_valid) begin
                    unique case (kind)
                        K_TABLE: begin
                            base_q <= nxt_base;
                            lvl    <= lvl + 2'd1;
                            state  <= S_LOOKUP;
                        end
                        K_BLOCK, K_PAGE: begin
                            resp_fault    <= 1'b0;
                            resp_pa       <= leaf_pa;
                            resp_syndrome <= '0;
                            state         <= S_DONE;
                        end
                        default: begin
                            resp_fault    <= 1'b1;
                            resp_pa       <= '0;
                            resp_syndrome <= abort_syndrome(wr_q, lvl);
                            fault_va      <= va_q;
                            state         <= S_DONE;
                        end
                    endcase
                end
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ptw_walker_checker.sv
module ptw_walker_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [63:0] req_va,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [47:0] mem_req_addr,
    input logic        resp_valid,
    input logic        resp_fault,
    input logic [31:0] resp_syndrome,
    input logic [63:0] fault_va
);
    // R11: a pending read holds its address until taken
    a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R11: once a request is taken the walker is busy
    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);

    // R12: result lasts one cycle
    a_r12_resp_pulse: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    // R7: fault syndrome class and status pattern
    a_r7_syndrome_form: assert property (@(posedge clk) disable iff (rst)
        resp_valid && resp_fault |-> resp_syndrome[31:26] == 6'b100101
                                     && resp_syndrome[5:2] == 4'b0001);

    // R2: malformed address faults at once without a read
    a_r2_noncanon_fast: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && !(&req_va[63:48]) && (|req_va[63:48])
        |=> resp_valid && resp_fault && !mem_req_valid && resp_syndrome[5:0] == 6'b000100);

    // R8: a successful result leaves the captured fault address alone
    a_r8_fault_va_kept: assert property (@(posedge clk) disable iff (rst)
        resp_valid && !resp_fault |-> $stable(fault_va));
endmodule

bind ptw_walker ptw_walker_checker u_chk (.*);

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_va = '0;
    logic        req_write = 1'b0;
    logic [47:0] base_lo = 48'h0000_0001_0000;
    logic [47:0] base_hi = 48'h0000_0002_0000;
    logic        inval = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [47:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        resp_valid;
    logic        resp_fault;
    logic [47:0] resp_pa;
    logic [31:0] resp_syndrome;
    logic [63:0] fault_va;

    always #2 clk = ~clk;

    ptw_walker u_ptw_walker (.*);

    // memory model
    logic [47:0] m_addr [32];
    logic [63:0] m_data [32];
    int          m_cnt = 0;
    int          rd_total = 0;
    logic [47:0] addr_log [16];
    logic        stall_en = 1'b0;
    logic [1:0]  stall_ph = '0;
    logic        rsp_v = 1'b0;
    logic [63:0] rsp_d = '0;

    assign mem_req_ready = !stall_en || (stall_ph == 2'b11);
    assign mem_rsp_valid = rsp_v;
    assign mem_rsp_data  = rsp_d;

    function automatic logic [63:0] mem_read(input logic [47:0] a);
        logic [63:0] d;
        d = '0;
        for (int i = 0; i < m_cnt; i++) if (m_addr[i] == a) d = m_data[i];
        return d;
    endfunction

    task automatic mem_set(input logic [47:0] a, input logic [63:0] d);
        int found;
        found = 0;
        for (int i = 0; i < m_cnt; i++) if (m_addr[i] == a) begin m_data[i] = d; found = 1; end
        if (found == 0) begin m_addr[m_cnt] = a; m_data[m_cnt] = d; m_cnt++; end
    endtask

    always @(posedge clk) begin
        stall_ph <= stall_ph + 2'd1;
        if (rst) begin
            rsp_v <= 1'b0;
        end else begin
            rsp_v <= mem_req_valid && mem_req_ready;
            if (mem_req_valid && mem_req_ready) begin
                rsp_d <= mem_read(mem_req_addr);
                addr_log[rd_total[3:0]] <= mem_req_addr;
                rd_total <= rd_total + 1;
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // walk results
    logic        w_fault;
    logic [31:0] w_syn;
    logic [47:0] w_pa;
    int          w_reads;
    logic [47:0] w_first;
    logic [63:0] w_fva;
    bit          saw_busy;

    task automatic walk(input logic [63:0] va, input logic wr);
        int start;
        bit done;
        @(negedge clk);
        start = rd_total;
        req_va = va; req_write = wr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        saw_busy = !req_ready;
        done = 0;
        for (int i = 0; i < 300; i++) begin
            if (resp_valid) begin done = 1; break; end
            if (req_ready) saw_busy = 0;
            @(negedge clk);
        end
        chk(done, "R12 result arrives", 64'(done), 64'd1);
        w_fault = resp_fault; w_syn = resp_syndrome; w_pa = resp_pa; w_fva = fault_va;
        w_reads = rd_total - start;
        w_first = addr_log[start[3:0]];
        @(negedge clk);
        chk(!resp_valid && req_ready, "R12 single-cycle result", {62'd0, resp_valid, req_ready}, 64'd1);
    endtask

    task automatic pulse_inval();
        @(negedge clk); inval = 1'b1;
        @(negedge clk); inval = 1'b0;
    endtask

    function automatic logic [31:0] exp_syn(input logic wr, input logic [5:0] fsc);
        return {6'b100101, 19'd0, wr, fsc};
    endfunction

    typedef struct packed {
        logic [63:0] va;
        logic        wr;
        logic        flt;
        logic [5:0]  fsc;
        logic [47:0] pa;
        logic [7:0]  reads;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0080_8060_4abc, 1'b0, 1'b0, 6'h00, 48'h000A_BCDE_Fabc, 8'd4},
        '{64'h0000_0080_80A1_2345, 1'b0, 1'b0, 6'h00, 48'h0000_4061_2345, 8'd3},
        '{64'h0000_0081_8123_4567, 1'b1, 1'b0, 6'h00, 48'h0000_8123_4567, 8'd2},
        '{64'h0000_0000_0000_1000, 1'b1, 1'b1, 6'b000100, 48'h0, 8'd1},
        '{64'h0000_0081_C000_0000, 1'b0, 1'b1, 6'b000101, 48'h0, 8'd2},
        '{64'h0000_0080_80C0_0000, 1'b1, 1'b1, 6'b000110, 48'h0, 8'd3},
        '{64'h0000_0080_8060_5000, 1'b0, 1'b1, 6'b000111, 48'h0, 8'd4},
        '{64'h0000_0100_0000_0000, 1'b0, 1'b1, 6'b000100, 48'h0, 8'd1},
        '{64'h0000_0080_8060_6000, 1'b1, 1'b1, 6'b000111, 48'h0, 8'd4},
        '{64'hFFFF_0100_8060_4abc, 1'b0, 1'b0, 6'h00, 48'h000A_BCDE_Fabc, 8'd4},
        '{64'h0001_0000_0000_0000, 1'b1, 1'b1, 6'b000100, 48'h0, 8'd0}
    };

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        mem_set(48'h10008, 64'h11003);
        mem_set(48'h10010, 64'h1);
        mem_set(48'h11010, 64'h12003);
        mem_set(48'h11030, 64'h8000_0001);
        mem_set(48'h12018, 64'h13003);
        mem_set(48'h12028, 64'h4060_0001);
        mem_set(48'h13020, 64'hA_BCDE_F003);
        mem_set(48'h13030, 64'h5001);
        mem_set(48'h20010, 64'h11003);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset state
        chk(req_ready && !resp_valid && !mem_req_valid && fault_va == 0, "R11 reset idle",
            {60'd0, req_ready, resp_valid, mem_req_valid, |fault_va}, 64'h8);

        // vector walk, cache cleared before each
        for (int v = 0; v < NV; v++) begin
            pulse_inval();
            walk(VECS[v].va, VECS[v].wr);
            chk(w_fault == VECS[v].flt, "R5 R6 R7 outcome kind", 64'(w_fault), 64'(VECS[v].flt));
            if (VECS[v].flt) begin
                chk(w_syn == exp_syn(VECS[v].wr, VECS[v].fsc), "R7 syndrome", 64'(w_syn),
                    64'(exp_syn(VECS[v].wr, VECS[v].fsc)));
                chk(w_fva == VECS[v].va, "R8 fault address", w_fva, VECS[v].va);
            end else begin
                chk(w_pa == VECS[v].pa, "R5 R6 physical address", 64'(w_pa), 64'(VECS[v].pa));
            end
            chk(w_reads == int'(VECS[v].reads), "R3 R4 descriptor reads", 64'(w_reads), 64'(VECS[v].reads));
        end

        // R2: malformed address, no read
        walk(64'h0001_0000_0000_0000, 1'b0);
        chk(w_reads == 0 && w_syn[5:0] == 6'b000100, "R2 malformed address", 64'(w_reads), 64'd0);

        // R1: base selection from first fetched address
        pulse_inval();
        walk(64'hFFFF_0100_8060_4abc, 1'b0);
        chk(w_first == 48'h20010, "R1 high base", 64'(w_first), 64'h20010);
        pulse_inval();
        walk(64'h0000_0080_8060_4abc, 1'b0);
        chk(w_first == 48'h10008, "R1 low base", 64'(w_first), 64'h10008);

        // R9: repeat hits the cache, only level 3 fetched
        walk(64'h0000_0080_8060_4abc, 1'b0);
        chk(w_reads == 1 && w_first == 48'h13020, "R9 cached walk", 64'(w_first), 64'h13020);
        chk(w_pa == 48'h000A_BCDE_Fabc, "R9 cached result", 64'(w_pa), 64'hABCDEFabc);

        // R9: stale pointer survives a table change
        mem_set(48'h10008, 64'h0);
        walk(64'h0000_0080_8060_4abc, 1'b0);
        chk(!w_fault && w_pa == 48'h000A_BCDE_Fabc, "R9 stale entry used", 64'(w_pa), 64'hABCDEFabc);

        // R10: invalidate exposes the change
        pulse_inval();
        walk(64'h0000_0080_8060_4abc, 1'b1);
        chk(w_fault && w_syn == exp_syn(1'b1, 6'b000100), "R10 walk restarts", 64'(w_syn),
            64'(exp_syn(1'b1, 6'b000100)));
        chk(w_reads == 1 && w_first == 48'h10008, "R10 level-0 fetch", 64'(w_first), 64'h10008);
        mem_set(48'h10008, 64'h11003);

        // R8: fault address held through a successful walk
        walk(64'h0000_0081_8123_4567, 1'b0);
        chk(!w_fault && w_fva == 64'h0000_0080_8060_4abc, "R8 fault address held", w_fva,
            64'h0000_0080_8060_4abc);

        // R11: slow memory, busy throughout
        stall_en = 1'b1;
        pulse_inval();
        walk(64'h0000_0080_80A1_2345, 1'b0);
        chk(w_pa == 48'h4061_2345 && w_reads == 3, "R11 stalled walk", 64'(w_pa), 64'h4061_2345);
        chk(saw_busy, "R11 not ready while walking", 64'(saw_busy), 64'd1);
        stall_en = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule